// File: doc/BRIEF.md
# Transmit Descriptor and Completion Queue Engine

This block walks a ring of transmit descriptors held in memory and, for every descriptor it takes, writes one completion entry into a second, independent ring. Software fills descriptors, then posts work by writing a count to a posting register. The engine adds that count to its outstanding total. While work is outstanding and the master enable is set, the engine reads each descriptor's control word and passes the buffer index, byte length and end-of-frame flag to a MAC transmit port. It then waits for the MAC's verdict and writes a packed completion word. After that write it steps the completion pointer and raises a transmit-done interrupt.

Each ring is described by a base address, a length in bytes and a current address. Entries are 8 bytes long. The control word sits at entry offset 4 of a descriptor, and the completion word sits at entry offset 0. Software learns how far the engine has got by comparing its own pointer with the completion ring's current address. A descriptor whose abort flag is set never reaches the MAC. The engine completes it at once with an aborted status.

Top module: `txq_engine`

## Requirements
- R1: After reset, no memory or MAC request is active, `irq` is low, every ring address reads 0 and the outstanding count is 0.
- R2: The engine makes no memory access while the outstanding count is zero or the master enable (control register 0x00, bit 8) is clear.
- R3: A descriptor fetch reads address current+4. From the word read, bit 31 is end-of-frame, bits 30:16 are the buffer index, bit 15 is abort and bits 11:0 are the length. Index, length and end-of-frame are presented on the MAC port and held until `mac_done`. Memory and MAC requests are never active together.
- R4: The completion word is written to the completion ring's current address. Its bit 31 is 1. Bit 30 is sent-ok, bit 29 is aborted, bit 26 is late collision, bit 25 is underrun and bit 24 is excess collisions. Bits 20:16 hold the collision count and bits 14:0 echo the descriptor's buffer index. All other bits are 0.
- R5: A MAC collision count above 31 is written as 31.
- R6: A descriptor with abort set issues no MAC request. Its completion word has bit 29 set, bit 30 clear and a collision count of 0.
- R7: Writing a ring base (descriptor 0x10, completion 0x20) also loads its current address (read at 0x18 / 0x28). The descriptor current address advances by 8 after each fetch and returns to the base on reaching base+length (length at 0x14).
- R8: The completion current address advances by 8 after each completion write and returns to the base on reaching base+length (length at 0x24).
- R9: Writing N to the posting register (0x2C) adds N to the outstanding count. The engine consumes exactly that many descriptors in ring order and then stays idle.
- R10: Each completion write sets interrupt status bit 3. `irq` is that bit ANDed with enable bit 3 (register 0x04). Reading 0x08 returns the status without changing it. Reading 0x0C returns the status and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| mac_req | output | 1 | Transmit request to MAC, held until `mac_done` |
| mac_idx | output | 15 | Buffer index for the MAC |
| mac_len | output | 12 | Frame byte length |
| mac_eof | output | 1 | End-of-frame flag |
| mac_done | input | 1 | MAC result valid (one cycle) |
| mac_ok | input | 1 | Frame sent without error |
| mac_ow | input | 1 | Late (out-of-window) collision |
| mac_urun | input | 1 | Transmit underrun |
| mac_xcol | input | 1 | Excess collisions |
| mac_coll | input | COLL_W | Collision count |
| irq | output | 1 | Transmit-done interrupt |

## Verification
The assertions assume that the memory side acknowledges only while a request is pending, and that `mac_done` arrives only while `mac_req` is high. They also assume that software never posts so much work that the outstanding count wraps. The bench responders act on the falling edge. Memory acknowledges one cycle after it sees a request, and the MAC answers three cycles after it sees one. The bench never posts more than a handful of descriptors. Descriptor memory is rewritten only for slots the engine has not yet fetched.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MAC   = 2'd2,
    ST_CMPL  = 2'd3
  } txq_state_e;

  localparam logic [5:0] RA_CTRL  = 6'h00;
  localparam logic [5:0] RA_IEN   = 6'h04;
  localparam logic [5:0] RA_IST   = 6'h08;
  localparam logic [5:0] RA_ISTRC = 6'h0C;
  localparam logic [5:0] RA_DBASE = 6'h10;
  localparam logic [5:0] RA_DLEN  = 6'h14;
  localparam logic [5:0] RA_DCUR  = 6'h18;
  localparam logic [5:0] RA_CBASE = 6'h20;
  localparam logic [5:0] RA_CLEN  = 6'h24;
  localparam logic [5:0] RA_CCUR  = 6'h28;
  localparam logic [5:0] RA_POST  = 6'h2C;

  localparam int ENTRY_BYTES = 8;
  localparam int CTRL_WORD_OFS = 4;
  localparam int EN_BIT  = 8;
  localparam int IRQ_BIT = 3;
  localparam int IDX_W = 15;
  localparam int LEN_W = 12;
endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic          len_we,
  input  logic [AW-1:0] wdata,
  input  logic          adv,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] cur_q
);
  logic [AW-1:0] cur_d, stepped, limit;

  always_comb begin
    stepped = cur_q + AW'(STEP);
    limit   = base_q + len_q;
    cur_d   = cur_q;
    if (base_we)  cur_d = wdata;
    else if (adv) cur_d = (stepped >= limit) ? base_q : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      cur_q  <= '0;
    end else begin
      if (base_we)          base_q <= wdata;
      if (len_we)           len_q  <= wdata;
      if (base_we || adv)   cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/txq_status_fmt.sv
module txq_status_fmt #(
  parameter int COLL_W = 8,
  parameter int IDX_W  = 15
) (
  input  logic              ok,
  input  logic              aborted,
  input  logic              late_col,
  input  logic              underrun,
  input  logic              excess_col,
  input  logic [COLL_W-1:0] coll,
  input  logic [IDX_W-1:0]  idx,
  output logic [31:0]       word
);
  logic [4:0] coll_sat;

  generate
    if (COLL_W > 5) begin : g_sat
      always_comb coll_sat = (coll > COLL_W'(31)) ? 5'd31 : coll[4:0];
    end else begin : g_direct
      always_comb coll_sat = 5'(coll);
    end
  endgenerate

  always_comb begin
    word        = '0;
    word[31]    = 1'b1;
    word[30]    = ok;
    word[29]    = aborted;
    word[26]    = late_col;
    word[25]    = underrun;
    word[24]    = excess_col;
    word[20:16] = coll_sat;
    word[14:0]  = 15'(idx);
  end
endmodule

// File: rtl/txq_engine.sv
module txq_engine
  import txq_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CNT_W  = 16,
  parameter int COLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              mac_req,
  output logic [14:0]       mac_idx,
  output logic [11:0]       mac_len,
  output logic              mac_eof,
  input  logic              mac_done,
  input  logic              mac_ok,
  input  logic              mac_ow,
  input  logic              mac_urun,
  input  logic              mac_xcol,
  input  logic [COLL_W-1:0] mac_coll,
  output logic              irq
);
  txq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  pend_q, pend_d;
  logic              en_q, ien_q, ist_q, ist_d;
  logic              eof_q, abort_q, eof_d, abort_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [4:0]        flg_q, flg_d;
  logic [COLL_W-1:0] coll_q, coll_d;
  logic              d_adv, c_adv, take, set_irq;
  logic              wr_dbase, wr_dlen, wr_cbase, wr_clen, wr_post, rd_clr;
  logic [AW-1:0]     dbase, dlen, dcur, cbase, clen, ccur;
  logic [31:0]       cmpl_word;
  logic              unused_bits;

  assign wr_dbase = reg_wr && (reg_addr == RA_DBASE);
  assign wr_dlen  = reg_wr && (reg_addr == RA_DLEN);
  assign wr_cbase = reg_wr && (reg_addr == RA_CBASE);
  assign wr_clen  = reg_wr && (reg_addr == RA_CLEN);
  assign wr_post  = reg_wr && (reg_addr == RA_POST);
  assign rd_clr   = reg_rd && (reg_addr == RA_ISTRC);

  txq_ring_ptr #(.AW(AW), .STEP(ENTRY_BYTES)) u_desc_ring (
    .clk(clk), .rst_n(rst_n), .base_we(wr_dbase), .len_we(wr_dlen),
    .wdata(AW'(reg_wdata)), .adv(d_adv),
    .base_q(dbase), .len_q(dlen), .cur_q(dcur));

  txq_ring_ptr #(.AW(AW), .STEP(ENTRY_BYTES)) u_cmpl_ring (
    .clk(clk), .rst_n(rst_n), .base_we(wr_cbase), .len_we(wr_clen),
    .wdata(AW'(reg_wdata)), .adv(c_adv),
    .base_q(cbase), .len_q(clen), .cur_q(ccur));

  txq_status_fmt #(.COLL_W(COLL_W), .IDX_W(IDX_W)) u_fmt (
    .ok(flg_q[4]), .aborted(flg_q[3]), .late_col(flg_q[2]),
    .underrun(flg_q[1]), .excess_col(flg_q[0]),
    .coll(coll_q), .idx(idx_q), .word(cmpl_word));

  // Next-state logic
  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    d_adv   = 1'b0;
    c_adv   = 1'b0;
    set_irq = 1'b0;
    eof_d   = eof_q;
    abort_d = abort_q;
    idx_d   = idx_q;
    len_d   = len_q;
    flg_d   = flg_q;
    coll_d  = coll_q;
    unique case (state_q)
      ST_IDLE: if (en_q && (pend_q != '0)) state_d = ST_FETCH;
      ST_FETCH: if (mem_ack) begin
        take    = 1'b1;
        d_adv   = 1'b1;
        eof_d   = mem_rdata[31];
        idx_d   = mem_rdata[30:16];
        abort_d = mem_rdata[15];
        len_d   = mem_rdata[11:0];
        if (mem_rdata[15]) begin
          flg_d   = 5'b01000;
          coll_d  = '0;
          state_d = ST_CMPL;
        end else begin
          state_d = ST_MAC;
        end
      end
      ST_MAC: if (mac_done) begin
        flg_d   = {mac_ok, 1'b0, mac_ow, mac_urun, mac_xcol};
        coll_d  = mac_coll;
        state_d = ST_CMPL;
      end
      ST_CMPL: if (mem_ack) begin
        c_adv   = 1'b1;
        set_irq = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    pend_d = pend_q + (wr_post ? reg_wdata[CNT_W-1:0] : '0) - (take ? CNT_W'(1) : '0);
    ist_d  = set_irq ? 1'b1 : (rd_clr ? 1'b0 : ist_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      en_q    <= 1'b0;
      ien_q   <= 1'b0;
      ist_q   <= 1'b0;
      eof_q   <= 1'b0;
      abort_q <= 1'b0;
      idx_q   <= '0;
      len_q   <= '0;
      flg_q   <= '0;
      coll_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wr_post || take) pend_q <= pend_d;
      if (reg_wr && (reg_addr == RA_CTRL)) en_q  <= reg_wdata[EN_BIT];
      if (reg_wr && (reg_addr == RA_IEN))  ien_q <= reg_wdata[IRQ_BIT];
      if (set_irq || rd_clr) ist_q <= ist_d;
      if (take) begin
        eof_q   <= eof_d;
        abort_q <= abort_d;
        idx_q   <= idx_d;
        len_q   <= len_d;
      end
      if (take || (state_q == ST_MAC && mac_done)) begin
        flg_q  <= flg_d;
        coll_q <= coll_d;
      end
    end
  end

  // Outputs
  assign mem_req   = (state_q == ST_FETCH) || (state_q == ST_CMPL);
  assign mem_we    = (state_q == ST_CMPL);
  assign mem_addr  = (state_q == ST_CMPL) ? ccur : (dcur + AW'(CTRL_WORD_OFS));
  assign mem_wdata = cmpl_word;
  assign mac_req   = (state_q == ST_MAC);
  assign mac_idx   = idx_q;
  assign mac_len   = len_q;
  assign mac_eof   = eof_q;
  assign irq       = ist_q && ien_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:  reg_rdata[EN_BIT]  = en_q;
      RA_IEN:   reg_rdata[IRQ_BIT] = ien_q;
      RA_IST,
      RA_ISTRC: reg_rdata[IRQ_BIT] = ist_q;
      RA_DBASE: reg_rdata = 32'(dbase);
      RA_DLEN:  reg_rdata = 32'(dlen);
      RA_DCUR:  reg_rdata = 32'(dcur);
      RA_CBASE: reg_rdata = 32'(cbase);
      RA_CLEN:  reg_rdata = 32'(clen);
      RA_CCUR:  reg_rdata = 32'(ccur);
      RA_POST:  reg_rdata = 32'(pend_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign unused_bits = ^{mem_rdata[14:12], abort_q};
endmodule

// File: rtl/txq_engine_chk.sv
module txq_engine_chk #(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [31:0]      mem_wdata,
  input logic             mac_req,
  input logic [14:0]      mac_idx,
  input logic             mac_done,
  input logic             ist_q,
  input logic             en_q,
  input logic [CNT_W-1:0] pend_q,
  input logic [AW-1:0]    dcur,
  input logic [AW-1:0]    dbase,
  input logic             wr_dbase
);
  p_fetch_needs_work_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && !mem_we) |-> $past((pend_q != '0) && en_q));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mac_req));

  p_mac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_req && !mac_done) |=> (mac_req && $stable(mac_idx)));

  p_processed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[31]);

  p_abort_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wdata[29]) |-> (!mem_wdata[30] && mem_wdata[20:16] == 5'd0));

  p_dcur_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dcur) && !$past(wr_dbase)) |-> ((dcur == $past(dcur) + AW'(8)) || (dcur == dbase)));

  p_pend_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q < $past(pend_q)) |-> $past(mem_req && mem_ack && !mem_we));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist_q) |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind txq_engine txq_engine_chk #(.AW(AW), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_wdata(mem_wdata), .mac_req(mac_req),
  .mac_idx(mac_idx), .mac_done(mac_done), .ist_q(ist_q), .en_q(en_q),
  .pend_q(pend_q), .dcur(dcur), .dbase(dbase), .wr_dbase(wr_dbase));

// File: tb/test_txq_engine.sv
module test_txq_engine;
  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mac_req, mac_eof, mac_done, mac_ok, mac_ow, mac_urun, mac_xcol;
  logic [14:0] mac_idx;
  logic [11:0] mac_len;
  logic [7:0]  mac_coll;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  int rd_n = 0, wr_n = 0, mac_n = 0;
  logic [31:0] mem [256];
  logic [31:0] cw_log [16];
  logic [31:0] ca_log [16];
  logic [14:0] mi_log [16];
  logic [11:0] ml_log [16];
  logic        me_log [16];
  logic        busy;
  int          mcnt;
  logic        c_ok, c_ow, c_ur, c_xc;
  logic [7:0]  c_coll;
  logic [31:0] rv;

  txq_engine i_txq_engine (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Memory model: acknowledge one cycle after a request is seen
  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        cw_log[wr_n] <= mem_wdata;
        ca_log[wr_n] <= mem_addr;
        wr_n <= wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
        rd_n <= rd_n + 1;
      end
    end else mem_ack <= 1'b0;
  end

  // MAC model: answers three cycles after a request is seen
  always @(negedge clk) begin
    if (!rst_n) begin
      mac_done <= 1'b0; busy <= 1'b0; mcnt <= 0;
    end else if (mac_done) mac_done <= 1'b0;
    else if (mac_req && !busy) begin
      busy <= 1'b1; mcnt <= 0;
      mi_log[mac_n] <= mac_idx; ml_log[mac_n] <= mac_len; me_log[mac_n] <= mac_eof;
      mac_n <= mac_n + 1;
    end else if (busy) begin
      mcnt <= mcnt + 1;
      if (mcnt == 1) begin
        busy <= 1'b0; mac_done <= 1'b1;
        mac_ok <= c_ok; mac_ow <= c_ow; mac_urun <= c_ur; mac_xcol <= c_xc; mac_coll <= c_coll;
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_wr(int n);
    for (int i = 0; i < 500 && wr_n < n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] dword(int seq, bit ab);
    return {1'b1, 15'(seq), ab, 3'b0, 12'(60 + 3 * seq)};
  endfunction

  function automatic logic [31:0] cword(bit ok, bit fa, bit ow, bit ur, bit xc, int coll, int idx);
    int s = (coll > 31) ? 31 : coll;
    return {1'b1, ok, fa, 2'b00, ow, ur, xc, 3'b000, 5'(s), 1'b0, 15'(idx)};
  endfunction

  function automatic int dslot_addr(int seq);  // descriptor ring: base 0x100, 4 entries
    return 32'h100 + 8 * (seq % 4) + 4;
  endfunction

  task automatic t_reset;
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 mac_req", 32'(mac_req), 0);
    check("R1 irq", 32'(irq), 0);
    rreg(6'h18, rv); check("R1 desc cur", rv, 0);
    rreg(6'h28, rv); check("R1 cmpl cur", rv, 0);
    rreg(6'h2C, rv); check("R1 outstanding", rv, 0);
  endtask

  task automatic t_setup;
    wreg(6'h10, 32'h100); wreg(6'h14, 32'h20);
    wreg(6'h20, 32'h200); wreg(6'h24, 32'h18);
    wreg(6'h04, 32'h8);
    rreg(6'h18, rv); check("R7 desc cur loads base", rv, 32'h100);
    rreg(6'h28, rv); check("R8 cmpl cur loads base", rv, 32'h200);
  endtask

  task automatic t_disabled;
    mem[dslot_addr(0) >> 2] = dword(0, 0);
    wreg(6'h2C, 1);
    repeat (20) @(negedge clk);
    check("R2 no access while disabled", 32'(rd_n + wr_n), 0);
    rreg(6'h2C, rv); check("R9 post adds count", rv, 1);
    wreg(6'h00, 32'h100);
    wait_wr(1);
  endtask

  task automatic t_basic;
    check("R3 fetch count", 32'(rd_n), 1);
    check("R3 mac idx", 32'(mi_log[0]), 0);
    check("R3 mac len", 32'(ml_log[0]), 60);
    check("R3 mac eof", 32'(me_log[0]), 1);
    check("R4 cmpl word", cw_log[0], cword(1, 0, 0, 0, 0, 2, 0));
    check("R4 cmpl addr", ca_log[0], 32'h200);
    rreg(6'h18, rv); check("R7 desc cur step", rv, 32'h108);
    rreg(6'h28, rv); check("R8 cmpl cur step", rv, 32'h208);
  endtask

  task automatic t_irq;
    check("R10 irq raised", 32'(irq), 1);
    rreg(6'h08, rv); check("R10 plain view", rv, 32'h8);
    check("R10 plain view keeps irq", 32'(irq), 1);
    rreg(6'h0C, rv); check("R10 clear view", rv, 32'h8);
    check("R10 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_sat;
    c_ok = 0; c_ow = 1; c_ur = 1; c_xc = 1; c_coll = 8'd40;
    mem[dslot_addr(1) >> 2] = dword(1, 0);
    wreg(6'h2C, 1); wait_wr(2);
    check("R5 saturated word", cw_log[1], cword(0, 0, 1, 1, 1, 40, 1));
    check("R5 coll field", 32'(cw_log[1][20:16]), 31);
  endtask

  task automatic t_abort;
    c_ok = 1; c_ow = 0; c_ur = 0; c_xc = 0; c_coll = 8'd2;
    mem[dslot_addr(2) >> 2] = dword(2, 1);
    wreg(6'h2C, 1); wait_wr(3);
    check("R6 no mac request", 32'(mac_n), 2);
    check("R6 abort word", cw_log[2], cword(0, 1, 0, 0, 0, 0, 2));
    check("R8 cmpl addr last slot", ca_log[2], 32'h210);
    rreg(6'h28, rv); check("R8 cmpl cur wraps", rv, 32'h200);
  endtask

  task automatic t_burst;
    for (int s = 3; s <= 5; s++) mem[dslot_addr(s) >> 2] = dword(s, 0);
    wreg(6'h2C, 3);
    for (int i = 0; i < 500 && mac_n < 3; i++) @(negedge clk);
    for (int s = 6; s <= 7; s++) mem[dslot_addr(s) >> 2] = dword(s, 0);
    wreg(6'h2C, 2);
    wait_wr(8);
    check("R9 total completions", 32'(wr_n), 8);
    for (int s = 3; s <= 7; s++) begin
      check("R9 ring order word", cw_log[s], cword(1, 0, 0, 0, 0, 2, s));
      check("R8 ring order addr", ca_log[s], 32'h200 + 32'(8 * (s % 3)));
      check("R3 burst mac len", 32'(ml_log[s - 1]), 32'(60 + 3 * s));
    end
    rreg(6'h18, rv); check("R7 desc cur wraps", rv, 32'h100);
    rreg(6'h28, rv); check("R8 cmpl cur final", rv, 32'h210);
  endtask

  task automatic t_idle;
    int snap = rd_n + wr_n;
    repeat (30) @(negedge clk);
    check("R9 idle after drain", 32'(rd_n + wr_n), 32'(snap));
    rreg(6'h2C, rv); check("R9 outstanding drained", rv, 0);
    check("R2 mem_req low", 32'(mem_req), 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    mem_rdata = '0; mac_ok = 0; mac_ow = 0; mac_urun = 0; mac_xcol = 0; mac_coll = '0;
    c_ok = 1; c_ow = 0; c_ur = 0; c_xc = 0; c_coll = 8'd2;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_setup;
    t_disabled;
    t_basic;
    t_irq;
    t_sat;
    t_abort;
    t_burst;
    t_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule